// File: doc/BRIEF.md
# Dual-Mode Pulse Counter with Capture Register

This block counts falling edges on slow external pulse lines and keeps a snapshot of the count for reading. The count is `2*HALF_W` bits wide (32 by default). It can run as one wide counter, or as two independent halves, each with its own pulse input. Every external input is asynchronous to the system clock. Each one passes through a two-stage synchronizer, and the block counts the falling edges it sees on the synchronized levels.

The lower half, or the whole counter in joined mode, has two pulse inputs. The effective pulse is the OR of the two, so a high level held on either one stops counting. A third pulse input drives the upper half. In joined mode that input is an auxiliary test clock, and it is accepted only while the top bit of the lower half is low. In split mode it is the upper counter's own count input.

An active-low clear zeroes the counter. While the active-low load strobe is asserted, the capture register follows the count on every clock. When the strobe returns high, the capture register holds its value. The mode pin is sampled only while reset is held.

Top module: `pulse_capture_counter`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `cap_o` is zero and the count is zero.
- R2: Each falling edge of the effective lower pulse (`cnt_a_i` OR `cnt_a_alt_i`) adds exactly one to the lower half, whichever of the two pins produced it.
- R3: While either lower pulse pin is held high, pulses on the other pin are not counted. Releasing the held pin creates one falling edge of the effective pulse, which counts once.
- R4: A synchronized low on `clear_n_i` forces all count bits to zero. It takes priority over a count edge in the same cycle.
- R5: In joined mode (mode value 0), a lower-half step from all ones to zero adds one to the upper half in the same clock cycle.
- R6: In joined mode, a falling edge on `cnt_b_i` adds one to the upper half only while bit `HALF_W-1` of the lower half is 0. Otherwise the edge is ignored.
- R7: In split mode (mode value 1), the upper half counts falling edges of `cnt_b_i` and nothing else. No carry passes from the lower half, and the lower half's top bit has no effect.
- R8: While the synchronized `load_n_i` is low, `cap_o` takes the count on every clock. While it is high, `cap_o` holds its value.
- R9: `mode_split_i` is sampled only while `rst` is high. Changes after reset has been released do not alter the counting mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; mode is sampled while it is high |
| mode_split_i | input | 1 | 0 = one joined counter, 1 = two independent halves |
| cnt_a_i | input | 1 | Asynchronous lower/whole pulse input |
| cnt_a_alt_i | input | 1 | Asynchronous alternate lower/whole pulse input |
| cnt_b_i | input | 1 | Asynchronous upper-half pulse (test clock in joined mode) |
| clear_n_i | input | 1 | Asynchronous active-low counter clear |
| load_n_i | input | 1 | Asynchronous active-low capture strobe |
| cap_o | output | 2*HALF_W | Captured count |

## Verification
The assertions assume that every pulse input stays at one level for at least two system clocks. With that assumption, the synchronizers deliver each level change and each falling edge appears as a single one-cycle event. The assertions also assume that `mode_split_i` is meaningful only during reset. The bench holds each pulse level for two clocks, changes every input on the falling clock edge, and waits for the counter to settle before it opens the capture strobe. It runs the block with an 8-bit half so that it can reach lower-half rollover and the top-bit gate within a short run.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic {
    MODE_JOINED = 1'b0,
    MODE_SPLIT  = 1'b1
  } mode_e;

  // index of each synchronized input inside the sync bank
  localparam int unsigned IN_A     = 0;
  localparam int unsigned IN_A_ALT = 1;
  localparam int unsigned IN_B     = 2;
  localparam int unsigned IN_CLR_N = 3;
  localparam int unsigned IN_LD_N  = 4;
  localparam int unsigned IN_COUNT = 5;
endpackage

// File: rtl/pcc_sync.sv
module pcc_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= IDLE;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= IDLE;
      else     chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pcc_edge.sv
module pcc_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_det
    assign fall[i] = prev[i] & ~lvl[i];
  end
endmodule

// File: rtl/pcc_core.sv
module pcc_core
  import pcc_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode,
  input  logic              clr,
  input  logic              step_lo,
  input  logic              step_hi,
  output logic [FULL_W-1:0] count
);
  logic [HALF_W-1:0] lo_q, hi_q;
  logic              lo_wrap;
  logic              hi_adv;

  assign lo_wrap = step_lo && (lo_q == {HALF_W{1'b1}});

  always_comb begin
    unique case (mode)
      MODE_SPLIT:  hi_adv = step_hi;
      MODE_JOINED: hi_adv = lo_wrap | (step_hi & ~lo_q[HALF_W-1]);
      default:     hi_adv = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (step_lo) lo_q <= lo_q + 1'b1;
      if (hi_adv)  hi_q <= hi_q + 1'b1;
    end
  end

  assign count = {hi_q, lo_q};
endmodule

// File: rtl/pcc_capture.sv
module pcc_capture #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (take) q <= d;
  end
endmodule

// File: rtl/pulse_capture_counter.sv
module pulse_capture_counter
  import pcc_pkg::*;
#(
  parameter int unsigned HALF_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned FULL_W     = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_split_i,
  input  logic              cnt_a_i,
  input  logic              cnt_a_alt_i,
  input  logic              cnt_b_i,
  input  logic              clear_n_i,
  input  logic              load_n_i,
  output logic [FULL_W-1:0] cap_o
);
  localparam logic [IN_COUNT-1:0] IDLE_LVL =
    IN_COUNT'((1 << IN_CLR_N) | (1 << IN_LD_N));

  logic [IN_COUNT-1:0] raw_in, sync_in;
  logic [1:0]          pulse_lvl, pulse_fall;
  logic                fall_a, fall_b, clr_act, ld_act;
  logic [FULL_W-1:0]   count_q;
  mode_e               mode_q;

  always_comb begin
    raw_in           = '0;
    raw_in[IN_A]     = cnt_a_i;
    raw_in[IN_A_ALT] = cnt_a_alt_i;
    raw_in[IN_B]     = cnt_b_i;
    raw_in[IN_CLR_N] = clear_n_i;
    raw_in[IN_LD_N]  = load_n_i;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode_split_i ? MODE_SPLIT : MODE_JOINED;
  end

  pcc_sync #(
    .WIDTH  (IN_COUNT),
    .STAGES (SYNC_STAGES),
    .IDLE   (IDLE_LVL)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_in),
    .dout (sync_in)
  );

  // a high on either lower pin blocks: merge after synchronizing
  assign pulse_lvl[0] = sync_in[IN_A] | sync_in[IN_A_ALT];
  assign pulse_lvl[1] = sync_in[IN_B];

  pcc_edge #(.WIDTH(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pulse_lvl),
    .fall (pulse_fall)
  );

  assign fall_a  = pulse_fall[0];
  assign fall_b  = pulse_fall[1];
  assign clr_act = ~sync_in[IN_CLR_N];
  assign ld_act  = ~sync_in[IN_LD_N];

  pcc_core #(.HALF_W(HALF_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .clr     (clr_act),
    .step_lo (fall_a),
    .step_hi (fall_b),
    .count   (count_q)
  );

  pcc_capture #(.WIDTH(FULL_W)) u_cap (
    .clk  (clk),
    .rst  (rst),
    .take (ld_act),
    .d    (count_q),
    .q    (cap_o)
  );
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker
  import pcc_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned FULL_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic [FULL_W-1:0] cap_o,
  input logic [FULL_W-1:0] count_q,
  input mode_e             mode_q,
  input logic              fall_a,
  input logic              fall_b,
  input logic              clr_act,
  input logic              ld_act
);
  logic [HALF_W-1:0] lo, hi;
  assign lo = count_q[HALF_W-1:0];
  assign hi = count_q[FULL_W-1:HALF_W];

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (cap_o == '0 && count_q == '0));

  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    (!clr_act && fall_a) |=> lo == $past(lo) + 1'b1);

  a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> count_q == '0);

  a_r5_carry: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_JOINED && !clr_act && fall_a && lo == {HALF_W{1'b1}})
      |=> hi == $past(hi) + 1'b1);

  a_r6_gate_blocked: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_JOINED && !clr_act && !fall_a && lo[HALF_W-1])
      |=> $stable(hi));

  a_r7_split_isolated: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SPLIT && !clr_act && !fall_b) |=> $stable(hi));

  a_r8_capture_take: assert property (@(posedge clk) disable iff (rst)
    ld_act |=> cap_o == $past(count_q));

  a_r8_capture_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_act |=> $stable(cap_o));

  a_r9_mode_fixed: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));
endmodule

bind pulse_capture_counter pcc_checker #(.HALF_W(HALF_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cap_o   (cap_o),
  .count_q (count_q),
  .mode_q  (mode_q),
  .fall_a  (fall_a),
  .fall_b  (fall_b),
  .clr_act (clr_act),
  .ld_act  (ld_act)
);

// File: tb/tb_pulse_capture_counter.sv
module tb_pulse_capture_counter;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 8;
  localparam int FW = 2 * HW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_split_i = 1'b0;
  logic cnt_a_i = 1'b0, cnt_a_alt_i = 1'b0, cnt_b_i = 1'b0;
  logic clear_n_i = 1'b1, load_n_i = 1'b1;
  logic [FW-1:0] cap_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [FW-1:0] exp_q[$];
  string         tag_q[$];
  event          chk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_capture_counter #(.HALF_W(HW)) dut (
    .clk(clk), .rst(rst), .mode_split_i(mode_split_i),
    .cnt_a_i(cnt_a_i), .cnt_a_alt_i(cnt_a_alt_i), .cnt_b_i(cnt_b_i),
    .clear_n_i(clear_n_i), .load_n_i(load_n_i), .cap_o(cap_o)
  );

  // monitor: pops one expected item per request and compares
  initial begin
    forever begin
      @(chk_ev);
      if (exp_q.size() != 0) begin
        logic [FW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if (cap_o !== e) begin
          n_fail++;
          $display("FAIL %s: cap_o=%h expected %h", t, cap_o, e);
        end
      end
    end
  end

  task automatic pulse(input int sel, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (sel)
        0: cnt_a_i = 1'b1;
        1: cnt_a_alt_i = 1'b1;
        default: cnt_b_i = 1'b1;
      endcase
      repeat (2) @(negedge clk);
      case (sel)
        0: cnt_a_i = 1'b0;
        1: cnt_a_alt_i = 1'b0;
        default: cnt_b_i = 1'b0;
      endcase
      @(negedge clk);
    end
  endtask

  task automatic expect_cap(input logic [FW-1:0] e, input string tag, input bit do_load);
    repeat (6) @(negedge clk);
    if (do_load) begin
      load_n_i = 1'b0;
      repeat (4) @(negedge clk);
      load_n_i = 1'b1;
      repeat (4) @(negedge clk);
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> chk_ev;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // joined mode
    do_reset();
    @(negedge clk);
    expect_cap(16'h0000, "R1 reset state", 1'b0);
    pulse(0, 5);
    expect_cap(16'h0005, "R2 pin A edges", 1'b1);
    pulse(1, 3);
    expect_cap(16'h0008, "R2 alt pin edges", 1'b1);

    @(negedge clk); cnt_a_alt_i = 1'b1;
    pulse(0, 3);
    expect_cap(16'h0008, "R3 alt held inhibits", 1'b1);
    @(negedge clk); cnt_a_alt_i = 1'b0;
    expect_cap(16'h0009, "R3 release counts once", 1'b1);

    pulse(2, 1);
    expect_cap(16'h0109, "R6 aux accepted msb low", 1'b1);

    @(negedge clk); clear_n_i = 1'b0;
    repeat (4) @(negedge clk); clear_n_i = 1'b1;
    expect_cap(16'h0000, "R4 clear", 1'b1);

    pulse(0, 2);
    @(negedge clk); cnt_a_i = 1'b1;
    repeat (3) @(negedge clk);
    cnt_a_i = 1'b0; clear_n_i = 1'b0;
    repeat (4) @(negedge clk); clear_n_i = 1'b1;
    expect_cap(16'h0000, "R4 clear beats edge", 1'b1);

    pulse(0, 128);
    pulse(2, 1);
    expect_cap(16'h0080, "R6 aux ignored msb high", 1'b1);
    pulse(0, 127);
    expect_cap(16'h00FF, "R2 lower all ones", 1'b1);
    pulse(0, 1);
    expect_cap(16'h0100, "R5 rollover carry", 1'b1);

    @(negedge clk); mode_split_i = 1'b1;
    pulse(0, 256);
    expect_cap(16'h0200, "R9 mode change ignored", 1'b1);

    pulse(0, 3);
    expect_cap(16'h0200, "R8 hold without strobe", 1'b0);
    expect_cap(16'h0203, "R8 take with strobe", 1'b1);

    // split mode
    do_reset();
    @(negedge clk);
    expect_cap(16'h0000, "R1 reset split", 1'b0);
    pulse(0, 256);
    expect_cap(16'h0000, "R7 no carry split", 1'b1);
    pulse(2, 2);
    pulse(0, 128);
    expect_cap(16'h0280, "R7 upper own input", 1'b1);
    pulse(2, 1);
    expect_cap(16'h0380, "R7 msb gate unused", 1'b1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule